// File: doc/BRIEF.md
# Dual-Width Synchronous FIFO Memory

The block is a 4,608-bit on-chip store run as a single-clock first-in first-out queue. The write side and the read side each pick their own word width from five organisations: 18, 9, 4, 2 or 1 bits. Data is treated as one continuous bit stream. A value pushed as one 4-bit word can therefore be popped as four single bits, and a run of single bits can be popped as wider words.

The controller keeps its own write and read pointers and an occupancy count, all in bits, so the flags stay exact whatever the two widths are. It drives four status outputs. Full means one more write word will not fit. Empty means less than one read word is held. Almost-full and almost-empty compare the occupancy against two programmable thresholds. The width selects are static configuration: change them only while reset is held.

Top module: `flex_fifo_mem`

## Requirements
- R1: While reset is held and on the first cycle after it, full=0, empty=1, afull=0, aempty=1 and rd_data=0.
- R2: Width codes are 3'd0=1 bit, 3'd1=2 bits, 3'd2=4 bits, 3'd3=9 bits and 3'd4=18 bits; codes 5 to 7 act as 1 bit. The capacity is 4,608 bits when both ports use the 9- or 18-bit code, and 4,096 bits otherwise.
- R3: Words leave in the order they were accepted, with every data bit preserved, including the ninth bit of each byte in the 9- and 18-bit organisations.
- R4: With different port widths, written words are packed least-significant bit first into one stream. A read word takes the oldest bits, with the oldest bit in bit 0.
- R5: full is 1 exactly when occupancy exceeds capacity minus the write width. A write while full is ignored and loses no stored data.
- R6: empty is 1 exactly when occupancy is below the read width. A read while empty is ignored and leaves rd_data unchanged.
- R7: A read and a write in the same cycle are both performed when each is allowed by the flags of that cycle.
- R8: rd_data is registered. It shows the popped word on the cycle after an accepted read, zero-filled above the read width, and holds its value when no read is accepted.
- R9: afull is 1 when occupancy in bits is greater than or equal to afull_thr, updated on the cycle after the access.
- R10: aempty is 1 when occupancy in bits is less than or equal to aempty_thr, updated on the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push request |
| wr_data | input | 18 | Push word; bits above the write width are ignored |
| wr_width | input | 3 | Write organisation code |
| rd_en | input | 1 | Pop request |
| rd_data | output | 18 | Popped word, registered |
| rd_width | input | 3 | Read organisation code |
| afull_thr | input | 13 | Almost-full threshold in bits |
| aempty_thr | input | 13 | Almost-empty threshold in bits |
| full | output | 1 | No room for one write word |
| empty | output | 1 | Less than one read word held |
| afull | output | 1 | Occupancy at or above afull_thr |
| aempty | output | 1 | Occupancy at or below aempty_thr |

## Verification
The hardest case to reach is a mixed-family setup, such as 18-bit writes with 4-bit reads. There the capacity is 4,096 bits, which is not a multiple of the write width. Words then straddle the wrap boundary at different offsets, and full asserts with some bits of space still free. The bench reaches this case with long runs of weighted random pushes and pops against a bit-level queue model. Write-biased phases pin the queue at full, and read-biased phases drain it, so the pointers wrap many times at changing offsets.

// File: rtl/flexfifo_pkg.sv
`timescale 1ns/1ps
package flexfifo_pkg;
   localparam int WB_W = 5;

   typedef enum logic [2:0] {
      PW_X1  = 3'd0,
      PW_X2  = 3'd1,
      PW_X4  = 3'd2,
      PW_X9  = 3'd3,
      PW_X18 = 3'd4
   } port_width_e;

   // bits carried by one word for a width code; unknown codes fall back to 1
   function automatic logic [WB_W-1:0] width_bits(input logic [2:0] code);
      case (code)
         PW_X2:   return 5'd2;
         PW_X4:   return 5'd4;
         PW_X9:   return 5'd9;
         PW_X18:  return 5'd18;
         default: return 5'd1;
      endcase
   endfunction

   function automatic logic is_byte_family(input logic [2:0] code);
      return (code == PW_X9) || (code == PW_X18);
   endfunction
endpackage

// File: rtl/flexfifo_geom.sv
`timescale 1ns/1ps
module flexfifo_geom
   import flexfifo_pkg::*;
#(
   parameter int TOTAL_BITS  = 4608,
   parameter int NARROW_BITS = 4096,
   parameter int CNT_W       = 13
) (
   input  logic [2:0]       wr_sel,
   input  logic [2:0]       rd_sel,
   output logic [WB_W-1:0]  wr_bits,
   output logic [WB_W-1:0]  rd_bits,
   output logic [CNT_W-1:0] cap
);
   assign wr_bits = width_bits(wr_sel);
   assign rd_bits = width_bits(rd_sel);
   // the ninth bit of each byte is only reachable when both ports use it
   assign cap = (is_byte_family(wr_sel) && is_byte_family(rd_sel))
                ? CNT_W'(TOTAL_BITS) : CNT_W'(NARROW_BITS);
endmodule

// File: rtl/flexfifo_wrap.sv
`timescale 1ns/1ps
module flexfifo_wrap #(
   parameter int W     = 13,
   parameter int INC_W = 5
) (
   input  logic [W-1:0]     base,
   input  logic [INC_W-1:0] inc,
   input  logic [W-1:0]     modulus,
   output logic [W-1:0]     sum
);
   logic [W:0] raw;
   assign raw = {1'b0, base} + {{(W + 1 - INC_W){1'b0}}, inc};
   assign sum = (raw >= {1'b0, modulus}) ? W'(raw - {1'b0, modulus}) : raw[W-1:0];
endmodule

// File: rtl/flexfifo_ctl.sv
`timescale 1ns/1ps
module flexfifo_ctl
   import flexfifo_pkg::*;
#(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [WB_W-1:0]  wr_bits,
   input  logic [WB_W-1:0]  rd_bits,
   input  logic [CNT_W-1:0] cap,
   input  logic [CNT_W-1:0] af_thr,
   input  logic [CNT_W-1:0] ae_thr,
   output logic             wr_ok,
   output logic             rd_ok,
   output logic [CNT_W-1:0] wptr,
   output logic [CNT_W-1:0] rptr,
   output logic             full,
   output logic             empty,
   output logic             afull,
   output logic             aempty
);
   logic [CNT_W-1:0] occ, occ_nxt, wptr_adv, rptr_adv;
   logic [CNT_W-1:0] w_add, r_sub;

   assign wr_ok = wr_en && !full;
   assign rd_ok = rd_en && !empty;

   flexfifo_wrap #(.W(CNT_W), .INC_W(WB_W)) u_wadv (
      .base(wptr), .inc(wr_bits), .modulus(cap), .sum(wptr_adv));
   flexfifo_wrap #(.W(CNT_W), .INC_W(WB_W)) u_radv (
      .base(rptr), .inc(rd_bits), .modulus(cap), .sum(rptr_adv));

   assign w_add   = wr_ok ? CNT_W'(wr_bits) : '0;
   assign r_sub   = rd_ok ? CNT_W'(rd_bits) : '0;
   assign occ_nxt = occ + w_add - r_sub;

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr   <= '0;
         rptr   <= '0;
         occ    <= '0;
         full   <= 1'b0;
         empty  <= 1'b1;
         afull  <= 1'b0;
         aempty <= 1'b1;
      end else begin
         if (wr_ok) wptr <= wptr_adv;
         if (rd_ok) rptr <= rptr_adv;
         occ    <= occ_nxt;
         full   <= occ_nxt > (cap - CNT_W'(wr_bits));
         empty  <= occ_nxt < CNT_W'(rd_bits);
         afull  <= occ_nxt >= af_thr;
         aempty <= occ_nxt <= ae_thr;
      end
   end

   // R5
   occ_bound_chk: assert property (@(posedge clk) disable iff (rst) occ <= cap);
   // R5
   wptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && full) |=> $stable(wptr));
   // R6
   rptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && empty) |=> $stable(rptr));
   // R6
   flags_excl_chk: assert property (@(posedge clk) disable iff (rst) !(full && empty));
   // R7
   both_move_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && rd_ok) |=> (wptr != $past(wptr)) && (rptr != $past(rptr)));
endmodule

// File: rtl/flexfifo_store.sv
`timescale 1ns/1ps
module flexfifo_store
   import flexfifo_pkg::*;
#(
   parameter int TOTAL_BITS = 4608,
   parameter int MAXW       = 18,
   parameter int CNT_W      = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_ok,
   input  logic [CNT_W-1:0] wptr,
   input  logic [WB_W-1:0]  wr_bits,
   input  logic [MAXW-1:0]  wr_data,
   input  logic             rd_ok,
   input  logic [CNT_W-1:0] rptr,
   input  logic [WB_W-1:0]  rd_bits,
   input  logic [CNT_W-1:0] cap,
   output logic [MAXW-1:0]  rd_data
);
   logic [TOTAL_BITS-1:0] mem;
   logic [CNT_W-1:0]      widx [MAXW];
   logic [CNT_W-1:0]      ridx [MAXW];
   logic [MAXW-1:0]       rd_word;

   // one address per bit lane, wrapping at the active capacity
   for (genvar g = 0; g < MAXW; g++) begin : g_lane
      flexfifo_wrap #(.W(CNT_W), .INC_W(WB_W)) u_wl (
         .base(wptr), .inc(WB_W'(g)), .modulus(cap), .sum(widx[g]));
      flexfifo_wrap #(.W(CNT_W), .INC_W(WB_W)) u_rl (
         .base(rptr), .inc(WB_W'(g)), .modulus(cap), .sum(ridx[g]));
      assign rd_word[g] = (WB_W'(g) < rd_bits) ? mem[ridx[g]] : 1'b0;
   end

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         for (int i = 0; i < MAXW; i++) begin
            if (WB_W'(i) < wr_bits) mem[widx[i]] <= wr_data[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        rd_data <= '0;
      else if (rd_ok) rd_data <= rd_word;
   end

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_ok |=> $stable(rd_data));
endmodule

// File: rtl/flex_fifo_mem.sv
`timescale 1ns/1ps
module flex_fifo_mem
   import flexfifo_pkg::*;
#(
   parameter int TOTAL_BITS  = 4608,
   parameter int NARROW_BITS = 4096,
   parameter int MAXW        = 18
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              wr_en,
   input  logic [MAXW-1:0]                   wr_data,
   input  logic [2:0]                        wr_width,
   input  logic                              rd_en,
   output logic [MAXW-1:0]                   rd_data,
   input  logic [2:0]                        rd_width,
   input  logic [$clog2(TOTAL_BITS+1)-1:0]   afull_thr,
   input  logic [$clog2(TOTAL_BITS+1)-1:0]   aempty_thr,
   output logic                              full,
   output logic                              empty,
   output logic                              afull,
   output logic                              aempty
);
   localparam int CNT_W = $clog2(TOTAL_BITS + 1);

   if (MAXW != 18) begin : g_bad_maxw
      $error("flex_fifo_mem: MAXW must be 18 to match the width codes");
   end
   if ((TOTAL_BITS % 18) != 0) begin : g_bad_total
      $error("flex_fifo_mem: TOTAL_BITS must be a multiple of 18");
   end
   if ((NARROW_BITS % 4) != 0 || NARROW_BITS > TOTAL_BITS || NARROW_BITS < 2 * MAXW) begin : g_bad_narrow
      $error("flex_fifo_mem: NARROW_BITS out of range");
   end

   logic [WB_W-1:0]  wr_bits, rd_bits;
   logic [CNT_W-1:0] cap, wptr, rptr;
   logic             wr_ok, rd_ok;

   flexfifo_geom #(.TOTAL_BITS(TOTAL_BITS), .NARROW_BITS(NARROW_BITS), .CNT_W(CNT_W)) u_geom (
      .wr_sel(wr_width), .rd_sel(rd_width),
      .wr_bits(wr_bits), .rd_bits(rd_bits), .cap(cap));

   flexfifo_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .wr_bits(wr_bits), .rd_bits(rd_bits), .cap(cap),
      .af_thr(afull_thr), .ae_thr(aempty_thr),
      .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr),
      .full(full), .empty(empty), .afull(afull), .aempty(aempty));

   flexfifo_store #(.TOTAL_BITS(TOTAL_BITS), .MAXW(MAXW), .CNT_W(CNT_W)) u_store (
      .clk(clk), .rst(rst), .wr_ok(wr_ok), .wptr(wptr), .wr_bits(wr_bits),
      .wr_data(wr_data), .rd_ok(rd_ok), .rptr(rptr), .rd_bits(rd_bits),
      .cap(cap), .rd_data(rd_data));
endmodule

// File: tb/flex_fifo_mem_bench.sv
`timescale 1ns/1ps
module flex_fifo_mem_bench;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
   logic [17:0] wr_data = '0, rd_data;
   logic [2:0]  wr_width = 3'd4, rd_width = 3'd4;
   logic [12:0] afull_thr = '0, aempty_thr = '0;
   logic        full, empty, afull, aempty;

   flex_fifo_mem u_flex_fifo_mem (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_width(wr_width),
      .rd_en(rd_en), .rd_data(rd_data), .rd_width(rd_width),
      .afull_thr(afull_thr), .aempty_thr(aempty_thr),
      .full(full), .empty(empty), .afull(afull), .aempty(aempty));

   int    n_cmp = 0, n_bad = 0;
   string cur_req = "R1";
   bit    mq[$];
   logic [17:0] exp_q[$];
   logic [17:0] exp_rd = '0;
   int    ww = 18, rw = 18, cap = 4608, thr_af = 0, thr_ae = 0;
   bit    rd_take = 0, mon_on = 0;
   bit    e_full, e_empty, e_af, e_ae;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic set_flags();
      e_full  = mq.size() > cap - ww;
      e_empty = mq.size() < rw;
      e_af    = mq.size() >= thr_af;
      e_ae    = mq.size() <= thr_ae;
   endtask

   // scoreboard monitor: pops the expected word after every accepted read
   always @(posedge clk) begin
      #2;
      if (mon_on) begin
         if (rd_take) begin
            exp_rd  = exp_q.pop_front();
            rd_take = 0;
         end
         check(rd_data === exp_rd, cur_req, "R8 rd_data", 32'(rd_data), 32'(exp_rd));
         check(full === e_full, cur_req, "full", 32'(full), 32'(e_full));
         check(empty === e_empty, cur_req, "empty", 32'(empty), 32'(e_empty));
         check(afull === e_af, cur_req, "afull", 32'(afull), 32'(e_af));
         check(aempty === e_ae, cur_req, "aempty", 32'(aempty), 32'(e_ae));
      end
   end

   task automatic restart(input logic [2:0] wc, input logic [2:0] rc, input int wb,
                          input int rb, input int af, input int ae);
      @(negedge clk);
      mon_on = 0; rst = 1; wr_en = 0; rd_en = 0; rd_take = 0;
      wr_width = wc; rd_width = rc;
      afull_thr = 13'(af); aempty_thr = 13'(ae);
      ww = wb; rw = rb; thr_af = af; thr_ae = ae;
      cap = (wb >= 9 && rb >= 9) ? 4608 : 4096;
      mq.delete(); exp_q.delete(); exp_rd = '0;
      @(posedge clk); #2;
      // R1 reset values
      check(full === 1'b0, "R1", "full", 32'(full), 0);
      check(empty === 1'b1, "R1", "empty", 32'(empty), 1);
      check(afull === 1'b0, "R1", "afull", 32'(afull), 0);
      check(aempty === 1'b1, "R1", "aempty", 32'(aempty), 1);
      check(rd_data === '0, "R1", "rd_data", 32'(rd_data), 0);
      @(negedge clk);
      rst = 0;
      set_flags();
      mon_on = 1;
   endtask

   // driver: applies one cycle and pushes the expected word into the queue
   task automatic step(input bit w, input bit r);
      logic [17:0] d, word;
      int n;
      @(negedge clk);
      d = 18'($urandom) & ((18'(1) << ww) - 18'(1));
      wr_en = w; rd_en = r; wr_data = d;
      n = mq.size();
      rd_take = r && (n >= rw);
      if (rd_take) begin
         word = '0;
         for (int i = 0; i < rw; i++) word[i] = mq.pop_front();
         exp_q.push_back(word);
      end
      if (w && !(n > cap - ww))
         for (int i = 0; i < ww; i++) mq.push_back(d[i]);
      set_flags();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      // R1 and R3: 18-bit on both ports
      restart(3'd4, 3'd4, 18, 18, 100, 20);
      cur_req = "R3";
      repeat (5) step(1, 0);
      repeat (6) step(0, 1);
      idle(2);
      // R5: fill to full, extra writes refused
      cur_req = "R5";
      repeat (260) step(1, 0);
      idle(2);
      // R6: drain, extra reads refused and data held
      cur_req = "R6";
      repeat (260) step(0, 1);
      idle(2);
      cur_req = "R5";
      repeat (7) step(1, 0);
      repeat (7) step(0, 1);
      repeat (258) step(1, 0);
      repeat (258) step(0, 1);
      // R7: simultaneous access
      cur_req = "R7";
      repeat (4) step(1, 0);
      repeat (40) step(1, 1);
      repeat (6) step(0, 1);
      idle(2);
      // R4: 4-bit writes read as single bits, then the reverse
      restart(3'd2, 3'd0, 4, 1, 4000, 0);
      cur_req = "R4";
      repeat (4) step(1, 0);
      repeat (18) step(0, 1);
      idle(2);
      restart(3'd0, 3'd2, 1, 4, 4000, 0);
      repeat (3) step(1, 0);
      cur_req = "R6";
      step(0, 1);
      cur_req = "R4";
      repeat (5) step(1, 0);
      repeat (3) step(0, 1);
      idle(2);
      // R3: 9-bit and 18-bit mixed, ninth bit kept
      restart(3'd3, 3'd4, 9, 18, 4000, 9);
      cur_req = "R3";
      repeat (7) step(1, 0);
      repeat (4) step(0, 1);
      idle(2);
      restart(3'd4, 3'd3, 18, 9, 4000, 9);
      repeat (3) step(1, 0);
      repeat (7) step(0, 1);
      idle(2);
      // R9 and R10: thresholds in bits
      restart(3'd0, 3'd0, 1, 1, 5, 2);
      cur_req = "R9";
      repeat (8) step(1, 0);
      cur_req = "R10";
      repeat (9) step(0, 1);
      idle(2);
      // R2: unknown code acts as a single bit
      restart(3'd7, 3'd0, 1, 1, 3, 1);
      cur_req = "R2";
      repeat (6) step(1, 0);
      repeat (7) step(0, 1);
      idle(2);
      // R2 and R5: 18-bit writes, 4-bit reads, 4096-bit capacity with wrap
      restart(3'd4, 3'd2, 18, 4, 3000, 500);
      cur_req = "R5";
      for (int k = 0; k < 4; k++) begin
         repeat (1500) step(($urandom % 4) != 0, ($urandom % 2) != 0);
         repeat (1500) step(($urandom % 6) == 0, 1'b1);
      end
      idle(3);
      summary();
      $finish;
   end
endmodule